// File: doc/BRIEF.md
# Scanline Interrupt Up-Counter

This block counts video scanlines and raises an interrupt toward the CPU after a programmable number of them. Software loads an 8-bit start value and arms the block through two register addresses. The counter then steps up by one on each qualifying scanline pulse. A pulse qualifies when the block is armed, the line number is inside the visible range and rendering is on. When a qualifying pulse finds the count already at 0xFF, the block raises its interrupt request and disarms itself. It does not reload, so software must load and arm it again for the next interrupt.

A two-state arming machine sits at the centre. ST_IDLE: pulses have no effect and the count holds. ST_ARMED: qualifying pulses count. There are four transitions. "arm": a write to the arm register with bit 0 set goes from ST_IDLE to ST_ARMED. "disarm": a write to the arm register with bit 0 clear goes from ST_ARMED to ST_IDLE. "fire": a qualifying pulse at count 0xFF goes from ST_ARMED to ST_IDLE and sets the request. "step": a qualifying pulse below 0xFF stays in ST_ARMED and increments the count. The interrupt request is a separate sticky flag. It is cleared only by the acknowledge input or by reset.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the interrupt request is low, the block is in ST_IDLE and the count is 0. Once the block is armed, the 256th qualifying pulse raises the request and none of the earlier 255 does.
- R2: A write to address 0xC000 loads the count with the 8-bit data byte.
- R3: A write to address 0xC001 arms the block when data bit 0 is 1 and disarms it when bit 0 is 0. The other data bits are ignored.
- R4: A scanline pulse counts only when the line number is 239 or lower and the rendering flag is high. Any other pulse leaves the count unchanged.
- R5: A qualifying pulse that finds the count at 0xFF raises the request on the following clock edge and returns the block to ST_IDLE. Later pulses have no effect until the block is armed again.
- R6: The request stays high until a cycle with the acknowledge input high. Writes to the arm register do not clear it.
- R7: In ST_IDLE the count holds its value through scanline pulses.
- R8: A register write in the same cycle as a scanline pulse takes effect, and that pulse is ignored.
- R9: Writes to any address other than 0xC000 and 0xC001 change neither the count nor the arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| line_pulse | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Current scanline number |
| render_on | input | 1 | High when background or sprite rendering is on |
| irq_ack | input | 1 | Clears a pending interrupt request |
| irq | output | 1 | Level interrupt request |

## Verification
The count is not visible at the ports, so every test loads a start value, sends qualifying pulses and watches the cycle in which the request rises. A start at 0xFD shows that counting works and that the block fires on the third pulse, not the second. After reset, the 256-pulse run shows that the count starts from zero. Pulses on line 240, pulses with rendering off and pulses while idle are placed between a 0xFE load and the valid pulses; if any of them counted, the request would rise one pulse early, so they are told apart from real counting. Writes that collide with a pulse, writes with stray data bits and writes to other addresses are judged by the same one-pulse offset. Checks on the request level before and after arm-register writes and the acknowledge show that the request is sticky.

// File: rtl/scirq_pkg.sv
package scirq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;
endpackage

// File: rtl/scirq_decode.sv
module scirq_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] LOAD_ADDR = 16'hC000,
    parameter logic [15:0] ARM_ADDR  = 16'hC001
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              load_hit,
    output logic              arm_hit,
    output logic              any_wr
);
    // Writes to other addresses are still writes: they block a same-cycle pulse.
    always_comb begin
        load_hit = wr_en && (wr_addr == LOAD_ADDR[ADDR_W-1:0]);
        arm_hit  = wr_en && (wr_addr == ARM_ADDR[ADDR_W-1:0]);
        any_wr   = wr_en;
    end
endmodule

// File: rtl/scirq_count.sv
module scirq_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_hit,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] count_q,
    output logic             at_top
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (load_hit) count_q <= load_val;
        else if (step)     count_q <= count_q + 1'b1;
    end

    assign at_top = (count_q == TOP);
endmodule

// File: rtl/scirq_ctrl.sv
module scirq_ctrl
    import scirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_hit,
    input  logic       arm_bit,
    input  logic       line_ok,
    input  logic       at_top,
    input  logic       irq_ack,
    output arm_state_t state_q,
    output logic       step,
    output logic       irq_q
);
    arm_state_t state_d;
    logic       fire;

    // Next-state process
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_hit && arm_bit) state_d = ST_ARMED;      // arm
            end
            ST_ARMED: begin
                if (arm_hit && !arm_bit) state_d = ST_IDLE;      // disarm
                else if (line_ok && at_top) begin                 // fire
                    fire    = 1'b1;
                    state_d = ST_IDLE;
                end else if (line_ok) step = 1'b1;               // step
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: sticky request, fire wins over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (fire)    irq_q <= 1'b1;
        else if (irq_ack) irq_q <= 1'b0;
    end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import scirq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          CNT_W     = 8,
    parameter int          LINE_W    = 9,
    parameter int          LAST_LINE = 239,
    parameter logic [15:0] LOAD_ADDR = 16'hC000,
    parameter logic [15:0] ARM_ADDR  = 16'hC001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_on,
    input  logic              irq_ack,
    output logic              irq
);
    localparam logic [LINE_W-1:0] LAST_L = LINE_W'(LAST_LINE);

    logic             load_hit, arm_hit, any_wr;
    logic             line_ok, step, at_top, irq_q;
    logic [CNT_W-1:0] count_q;
    arm_state_t       state_q;

    scirq_decode #(.ADDR_W(ADDR_W), .LOAD_ADDR(LOAD_ADDR), .ARM_ADDR(ARM_ADDR)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr),
        .load_hit(load_hit), .arm_hit(arm_hit), .any_wr(any_wr)
    );

    // A pulse qualifies on visible lines with rendering on and no write this cycle.
    assign line_ok = line_pulse && (line_num <= LAST_L) && render_on && !any_wr;

    scirq_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_hit(load_hit), .load_val(wr_data),
        .step(step), .count_q(count_q), .at_top(at_top)
    );

    scirq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm_hit(arm_hit), .arm_bit(wr_data[0]),
        .line_ok(line_ok), .at_top(at_top), .irq_ack(irq_ack),
        .state_q(state_q), .step(step), .irq_q(irq_q)
    );

    assign irq = irq_q;
endmodule

// File: rtl/scanline_irq_counter_chk.sv
module scanline_irq_counter_chk
    import scirq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int LINE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              line_pulse,
    input logic [LINE_W-1:0] line_num,
    input logic              render_on,
    input logic              irq_ack,
    input logic              irq,
    input logic [CNT_W-1:0]  count_q,
    input arm_state_t        state_q
);
    a_r2_load_takes_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 16'hC000) |=> count_q == $past(wr_data));

    a_r4_offscreen_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (line_num > 9'd239 || !render_on)) |=> $stable(count_q));

    a_r5_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> state_q == ST_IDLE);

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_en) |=> $stable(count_q));

    a_r8_write_blocks_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !irq) |=> !irq);

    a_r9_other_addr_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 16'hC000 && wr_addr != 16'hC001)
        |=> ($stable(count_q) && $stable(state_q)));
endmodule

bind scanline_irq_counter scanline_irq_counter_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W)
) u_chk (.*);

// File: tb/scanline_irq_counter_tb.sv
`timescale 1ns/1ps
module scanline_irq_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_pulse = 1'b0;
    logic [8:0]  line_num = '0;
    logic        render_on = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    scanline_irq_counter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .line_pulse(line_pulse), .line_num(line_num), .render_on(render_on),
        .irq_ack(irq_ack), .irq(irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Inputs change on the falling edge; the rising edge in between samples them.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int ln, input logic rend);
        line_pulse = 1'b1; line_num = 9'(ln); render_on = rend;
        @(negedge clk);
        line_pulse = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset_full_run();
        check("R1 reset", irq, 1'b0);
        wr(16'hC001, 8'h01);
        for (int i = 0; i < 255; i++) pulse(10, 1'b1);
        check("R1 no fire after 255", irq, 1'b0);
        pulse(10, 1'b1);
        check("R1 fire on 256th", irq, 1'b1);
        ack();
    endtask

    task automatic t_load_and_fire();
        wr(16'hC000, 8'hFD);
        wr(16'hC001, 8'h01);
        pulse(0, 1'b1); pulse(239, 1'b1);
        check("R2 load FD two pulses", irq, 1'b0);
        pulse(100, 1'b1);
        check("R5 fire at FF", irq, 1'b1);
        ack();
        for (int i = 0; i < 300; i++) pulse(50, 1'b1);
        check("R5 self-disarm", irq, 1'b0);
    endtask

    task automatic t_qualify();
        wr(16'hC000, 8'hFE);
        wr(16'hC001, 8'h01);
        pulse(240, 1'b1); pulse(261, 1'b1); pulse(239, 1'b0); pulse(5, 1'b0);
        pulse(20, 1'b1);
        check("R4 unqualified pulses held count", irq, 1'b0);
        pulse(239, 1'b1);
        check("R4 fire at line 239", irq, 1'b1);
        ack();
    endtask

    task automatic t_idle_hold();
        wr(16'hC000, 8'hFE);
        wr(16'hC001, 8'h02);              // bit 0 clear: stays idle
        for (int i = 0; i < 5; i++) pulse(30, 1'b1);
        check("R7 idle no fire", irq, 1'b0);
        wr(16'hC001, 8'hFF);              // bit 0 set: arm
        pulse(30, 1'b1);
        check("R3 R7 count held while idle", irq, 1'b0);
        pulse(30, 1'b1);
        check("R3 fire after arm", irq, 1'b1);
    endtask

    task automatic t_sticky();
        repeat (5) @(negedge clk);
        check("R6 held without ack", irq, 1'b1);
        wr(16'hC001, 8'h00);
        wr(16'hC001, 8'h01);
        check("R6 arm writes keep irq", irq, 1'b1);
        ack();
        check("R6 ack clears", irq, 1'b0);
    endtask

    task automatic t_collision();
        wr(16'hC000, 8'hFF);
        wr(16'hC001, 8'h01);
        // Load FE in the same cycle as a pulse: load wins, pulse ignored.
        wr_en = 1'b1; wr_addr = 16'hC000; wr_data = 8'hFE;
        line_pulse = 1'b1; line_num = 9'd7; render_on = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; line_pulse = 1'b0;
        check("R8 collision no fire", irq, 1'b0);
        pulse(7, 1'b1);
        check("R8 pulse was ignored", irq, 1'b0);
        pulse(7, 1'b1);
        check("R8 fire after FE", irq, 1'b1);
        ack();
    endtask

    task automatic t_other_addr();
        wr(16'hC000, 8'hFE);
        wr(16'hC001, 8'h01);
        wr(16'hC002, 8'hFF);
        wr(16'h8000, 8'h00);
        wr(16'hE001, 8'h00);
        pulse(1, 1'b1);
        check("R9 other writes ignored", irq, 1'b0);
        pulse(1, 1'b1);
        check("R9 still armed and fires", irq, 1'b1);
        ack();
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: irq=%b expected end of run", irq);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_full_run();
        t_load_and_fire();
        t_qualify();
        t_idle_hold();
        t_sticky();
        t_collision();
        t_other_addr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule